// File: doc/BRIEF.md
# Clean-Owner Coherence Directory

This block is a small on-chip directory that keeps track of which of a group of private caches hold each block. For every tracked block it keeps a holder bit-vector and an owner number, in place of duplicated tag arrays. A fully associative table with a fixed number of slots holds the entries. Caches send three kinds of request: a read miss, a notice that a clean copy was dropped, and a spill that pushes a block into a peer cache. Each request is accepted in one cycle. It produces at most one command beat.

A read miss goes to a peer cache whenever any other cache holds the block, and goes off-chip only when none does. When a request leaves exactly one holder, the beat also carries a singlet notice that tells that cache its copy is the last one on chip. Ownership moves to a remaining holder when the owner drops its copy. A spill first records the recipient as holder and owner, then tells the source to send the data. Both edges use valid/ready handshakes. The command output is a single registered slot.

Top module: `dir_clean_owner`

## Requirements
- R1: A read (op 0) for a block that some other cache holds yields a beat with action 1 (forward). The target is the lowest-numbered holder other than the requester, and the requester is added as a holder.
- R2: A read that finds no other holder yields action 2 (memory fetch) with the singlet flag set. The requester becomes the sole holder and the owner, and is named as the singlet target.
- R3: A clean drop (op 1) removes the source from the holders. If exactly one holder is left, a beat with action 0 and the singlet flag names that holder.
- R4: When the owner drops its copy and holders remain, ownership passes to the lowest-numbered remaining holder. Every beat reports the block's owner after the request.
- R5: A block whose holder vector becomes empty is removed from the table and produces no beat. Its slot becomes free, and a later read of that block fetches from memory.
- R6: A spill (op 2) removes the source, adds the recipient and makes the recipient owner. It yields action 3 (transfer) with the source as target and the recipient in the requester field. The singlet flag is set when the spill leaves exactly one holder and changed the holder set. A spill of an untracked block takes a new slot.
- R7: With every slot in use, a read or spill of an untracked block holds req_ready low, while requests for tracked blocks are still accepted.
- R8: A clean drop for an untracked block, or from a cache that does not hold the block, and op 3 produce no beat and change no state.
- R9: A beat stays valid and unchanged while rsp_ready is low. While the slot is full and not draining, req_ready is low. One request is taken per cycle, in arrival order.
- R10: After reset, rsp_valid is low, req_ready is high and no block is tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_op | input | 2 | 0 read, 1 clean drop, 2 spill, 3 no-op |
| req_src | input | ID_W | Issuing cache |
| req_dst | input | ID_W | Spill recipient |
| req_addr | input | ADDR_W | Block address |
| rsp_valid | output | 1 | Command beat present |
| rsp_ready | input | 1 | Command beat taken |
| rsp_act | output | 2 | 0 none, 1 forward, 2 memory fetch, 3 transfer |
| rsp_tgt | output | ID_W | Cache (or requester for fetch) that acts |
| rsp_req | output | ID_W | Requester, or spill recipient |
| rsp_sgl | output | 1 | Singlet notice present |
| rsp_sgl_tgt | output | ID_W | Cache that now holds the only copy |
| rsp_own | output | ID_W | Owner of the block after the request |
| rsp_addr | output | ADDR_W | Block address |

## Verification
The bench targets the forward-target choice when the requester is itself the lowest holder. A design that skipped the requester there would forward to itself instead of the next holder. It drops copies in an order that moves ownership twice and then shrinks the set to one holder. A design that kept a stale owner, or missed the singlet notice, would report the wrong owner in the next forward beat or omit the flag. It fills the table, parks an untracked read against it and frees a slot, which catches allocation that overwrites a live slot or never stalls. Held output beats under backpressure catch a slot that is overwritten before it is taken.

// File: rtl/dir_pkg.sv
package dir_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PUTS  = 2'd1,
        OP_SPILL = 2'd2,
        OP_NOP   = 2'd3
    } dir_op_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_FWD  = 2'd1,
        ACT_MEM  = 2'd2,
        ACT_XFER = 2'd3
    } dir_act_e;
endpackage

// File: rtl/dir_lowbit.sv
// Priority encoder: index of the lowest set bit.
module dir_lowbit #(
    parameter int W = 4,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dir_match.sv
// Associative lookup over the table tags plus free-slot choice.
module dir_match #(
    parameter int ENTRIES = 8,
    parameter int AW      = 16,
    localparam int EW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]         vld,
    input  logic [ENTRIES-1:0][AW-1:0] tags,
    input  logic [AW-1:0]              key,
    output logic                       hit,
    output logic [EW-1:0]              hit_idx,
    output logic                       free_any,
    output logic [EW-1:0]              free_idx
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = vld[g] && (tags[g] == key);
    end

    dir_lowbit #(.W(ENTRIES)) u_hit (
        .vec (eq),
        .any (hit),
        .idx (hit_idx)
    );

    dir_lowbit #(.W(ENTRIES)) u_free (
        .vec (~vld),
        .any (free_any),
        .idx (free_idx)
    );
endmodule

// File: rtl/dir_clean_owner.sv
module dir_clean_owner
    import dir_pkg::*;
#(
    parameter int NCACHE  = 4,
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 16,
    localparam int ID_W = (NCACHE > 1) ? $clog2(NCACHE) : 1,
    localparam int EI_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ID_W-1:0]   req_src,
    input  logic [ID_W-1:0]   req_dst,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_act,
    output logic [ID_W-1:0]   rsp_tgt,
    output logic [ID_W-1:0]   rsp_req,
    output logic              rsp_sgl,
    output logic [ID_W-1:0]   rsp_sgl_tgt,
    output logic [ID_W-1:0]   rsp_own,
    output logic [ADDR_W-1:0] rsp_addr
);
    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][ADDR_W-1:0] tag;
        logic [ENTRIES-1:0][NCACHE-1:0] shr;
        logic [ENTRIES-1:0][ID_W-1:0]   own;
        logic                           rv;
        dir_act_e                       act;
        logic [ID_W-1:0]                tgt;
        logic [ID_W-1:0]                rq;
        logic                           sgl;
        logic [ID_W-1:0]                stg;
        logic [ID_W-1:0]                ow;
        logic [ADDR_W-1:0]              addr;
    } st_t;

    st_t st_d, st_q;

    dir_op_e          op;
    logic             hit, free_any, need_alloc, fire, eff, sgl, beat;
    logic [EI_W-1:0]  hit_idx, free_idx, sel;
    logic [NCACHE-1:0] src_bit, dst_bit, cur, others, nv;
    logic [ID_W-1:0]  cur_own, new_own, act_tgt, oth_idx, nv_idx;
    logic             oth_any, nv_any;
    dir_act_e         act;

    assign op      = dir_op_e'(req_op);
    assign src_bit = NCACHE'(1) << req_src;
    assign dst_bit = NCACHE'(1) << req_dst;

    dir_match #(.ENTRIES(ENTRIES), .AW(ADDR_W)) u_match (
        .vld      (st_q.vld),
        .tags     (st_q.tag),
        .key      (req_addr),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .free_any (free_any),
        .free_idx (free_idx)
    );

    assign cur     = hit ? st_q.shr[hit_idx] : '0;
    assign cur_own = hit ? st_q.own[hit_idx] : '0;
    assign others  = cur & ~src_bit;
    assign sel     = hit ? hit_idx : free_idx;

    dir_lowbit #(.W(NCACHE)) u_first (
        .vec (others),
        .any (oth_any),
        .idx (oth_idx)
    );

    // Holder vector and action after the request.
    always_comb begin
        act     = ACT_NONE;
        act_tgt = req_src;
        nv      = cur;
        eff     = 1'b0;
        unique case (op)
            OP_READ: begin
                eff = 1'b1;
                if (oth_any) begin
                    act     = ACT_FWD;
                    act_tgt = oth_idx;
                    nv      = cur | src_bit;
                end else begin
                    act = ACT_MEM;
                    nv  = src_bit;
                end
            end
            OP_PUTS: begin
                eff = hit;
                nv  = cur & ~src_bit;
            end
            OP_SPILL: begin
                eff = 1'b1;
                act = ACT_XFER;
                nv  = (cur & ~src_bit) | dst_bit;
            end
            default: eff = 1'b0;
        endcase
    end

    dir_lowbit #(.W(NCACHE)) u_remain (
        .vec (nv),
        .any (nv_any),
        .idx (nv_idx)
    );

    assign need_alloc = !hit && (op == OP_READ || op == OP_SPILL);
    assign req_ready  = (!st_q.rv || rsp_ready) && (!need_alloc || free_any);
    assign fire       = req_valid && req_ready;

    always_comb begin
        st_d = st_q;

        unique case (op)
            OP_READ:  new_own = oth_any ? cur_own : req_src;
            OP_PUTS:  new_own = (cur_own == req_src && nv_any) ? nv_idx : cur_own;
            OP_SPILL: new_own = req_dst;
            default:  new_own = cur_own;
        endcase

        sgl  = eff && ($countones(nv) == 1) && ((nv != cur) || op == OP_READ);
        beat = eff && ((act != ACT_NONE) || sgl);

        if (st_q.rv && rsp_ready) st_d.rv = 1'b0;

        if (fire && beat) begin
            st_d.rv   = 1'b1;
            st_d.act  = act;
            st_d.tgt  = act_tgt;
            st_d.rq   = (op == OP_SPILL) ? req_dst : req_src;
            st_d.sgl  = sgl;
            st_d.stg  = nv_idx;
            st_d.ow   = new_own;
            st_d.addr = req_addr;
        end

        if (fire && eff) begin
            st_d.vld[sel] = nv_any;
            st_d.tag[sel] = req_addr;
            st_d.shr[sel] = nv;
            st_d.own[sel] = new_own;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid   = st_q.rv;
    assign rsp_act     = st_q.act;
    assign rsp_tgt     = st_q.tgt;
    assign rsp_req     = st_q.rq;
    assign rsp_sgl     = st_q.sgl;
    assign rsp_sgl_tgt = st_q.stg;
    assign rsp_own     = st_q.ow;
    assign rsp_addr    = st_q.addr;
endmodule

// File: rtl/dir_clean_owner_chk.sv
module dir_clean_owner_chk #(
    parameter int NCACHE = 4,
    parameter int ADDR_W = 16,
    localparam int ID_W = (NCACHE > 1) ? $clog2(NCACHE) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [1:0]        rsp_act,
    input logic [ID_W-1:0]   rsp_tgt,
    input logic [ID_W-1:0]   rsp_req,
    input logic              rsp_sgl,
    input logic [ID_W-1:0]   rsp_sgl_tgt,
    input logic [ID_W-1:0]   rsp_own,
    input logic [ADDR_W-1:0] rsp_addr
);
    p_fwd_other_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_act == 2'd1 |-> rsp_tgt != rsp_req && !rsp_sgl);

    p_mem_sgl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_act == 2'd2 |-> rsp_sgl && rsp_sgl_tgt == rsp_req && rsp_own == rsp_req);

    p_none_has_sgl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_act == 2'd0 |-> rsp_sgl && rsp_own == rsp_sgl_tgt);

    p_xfer_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_act == 2'd3 |-> rsp_own == rsp_req);

    p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |-> !req_ready);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_act) && $stable(rsp_tgt)
            && $stable(rsp_req) && $stable(rsp_sgl) && $stable(rsp_sgl_tgt)
            && $stable(rsp_own) && $stable(rsp_addr));
endmodule

bind dir_clean_owner dir_clean_owner_chk #(.NCACHE(NCACHE), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_act     (rsp_act),
    .rsp_tgt     (rsp_tgt),
    .rsp_req     (rsp_req),
    .rsp_sgl     (rsp_sgl),
    .rsp_sgl_tgt (rsp_sgl_tgt),
    .rsp_own     (rsp_own),
    .rsp_addr    (rsp_addr)
);

// File: tb/dir_clean_owner_tb.sv
`timescale 1ns/1ps
module dir_clean_owner_tb;
    localparam int SLOTS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [1:0]  req_op = '0;
    logic [1:0]  req_src = '0, req_dst = '0;
    logic [15:0] req_addr = '0;
    logic        rsp_valid, rsp_ready = 1'b1;
    logic [1:0]  rsp_act, rsp_tgt, rsp_req, rsp_sgl_tgt, rsp_own;
    logic        rsp_sgl;
    logic [15:0] rsp_addr;

    always #2.5 clk = ~clk;

    dir_clean_owner u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_src(req_src), .req_dst(req_dst), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_act(rsp_act),
        .rsp_tgt(rsp_tgt), .rsp_req(rsp_req), .rsp_sgl(rsp_sgl),
        .rsp_sgl_tgt(rsp_sgl_tgt), .rsp_own(rsp_own), .rsp_addr(rsp_addr)
    );

    typedef struct {
        int act; int tgt; int rq; int sgl; int stg; int own; int addr;
    } beat_t;

    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;
    bit [3:0] m_shr[int];
    int    m_own[int];
    beat_t exp_q[$];

    task automatic chk(bit ok, string rq, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic int lowest(bit [3:0] v);
        for (int i = 3; i >= 0; i--) if (v[i]) lowest = i;
        if (v == 0) lowest = 0;
    endfunction

    // Reference behaviour, applied when a request is accepted.
    task automatic model(int op, int src, int dst, int addr);
        bit [3:0] sb, db, cur, oth, nv;
        int co, no, act, tgt, rq;
        bit hit, sgl;
        beat_t b;
        sb = 4'(1 << src); db = 4'(1 << dst);
        hit = m_shr.exists(addr);
        cur = hit ? m_shr[addr] : 4'd0;
        co  = hit ? m_own[addr] : 0;
        act = 0; tgt = src; rq = src; no = co;
        if (op == 0) begin
            oth = cur & ~sb;
            if (oth != 0) begin act = 1; tgt = lowest(oth); nv = cur | sb; end
            else begin act = 2; nv = sb; no = src; end
        end else if (op == 1) begin
            if (!hit) return;
            nv = cur & ~sb;
            if (co == src && nv != 0) no = lowest(nv);
        end else if (op == 2) begin
            nv = (cur & ~sb) | db; no = dst; act = 3; rq = dst;
        end else return;
        sgl = ($countones(nv) == 1) && (nv != cur || op == 0);
        if (nv == 0) begin
            if (hit) begin m_shr.delete(addr); m_own.delete(addr); end
        end else begin
            m_shr[addr] = nv; m_own[addr] = no;
        end
        if (act != 0 || sgl) begin
            b.act = act; b.tgt = tgt; b.rq = rq; b.sgl = sgl;
            b.stg = lowest(nv); b.own = no; b.addr = addr;
            exp_q.push_back(b);
        end
    endtask

    function automatic string tag_of(int act);
        case (act)
            1: tag_of = "R1";
            2: tag_of = "R2";
            3: tag_of = "R6";
            default: tag_of = "R3";
        endcase
    endfunction

    // One clock: drive at the falling edge, check ready, update, check beat.
    task automatic cyc(bit v, int op, int src, int dst, int addr, bit rr);
        bit hit, need, er;
        beat_t e;
        req_valid = v; req_op = op[1:0]; req_src = src[1:0];
        req_dst = dst[1:0]; req_addr = addr[15:0]; rsp_ready = rr;
        #1;
        hit  = m_shr.exists(addr);
        need = !hit && (op == 0 || op == 2);
        er   = (exp_q.size() == 0 || rr) && (!need || m_shr.num() < SLOTS);
        if (v) chk(req_ready === er, (need && m_shr.num() >= SLOTS) ? "R7" : "R9",
                   int'(req_ready), int'(er));
        @(posedge clk);
        if (exp_q.size() > 0 && rr) void'(exp_q.pop_front());
        if (v && er) model(op, src, dst, addr);
        @(negedge clk);
        chk(rsp_valid === (exp_q.size() > 0), "R8/R9 valid", int'(rsp_valid), exp_q.size());
        if (exp_q.size() > 0 && rsp_valid === 1'b1) begin
            e = exp_q[0];
            chk(int'(rsp_act) == e.act, tag_of(e.act), int'(rsp_act), e.act);
            if (e.act != 0) begin
                chk(int'(rsp_tgt) == e.tgt, tag_of(e.act), int'(rsp_tgt), e.tgt);
                chk(int'(rsp_req) == e.rq, tag_of(e.act), int'(rsp_req), e.rq);
            end
            chk(int'(rsp_sgl) == e.sgl, "R3 singlet", int'(rsp_sgl), e.sgl);
            if (e.sgl != 0) chk(int'(rsp_sgl_tgt) == e.stg, "R3 singlet tgt", int'(rsp_sgl_tgt), e.stg);
            chk(int'(rsp_own) == e.own, "R4 owner", int'(rsp_own), e.own);
            chk(int'(rsp_addr) == e.addr, "R9 addr", int'(rsp_addr), e.addr);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(rsp_valid === 1'b0, "R10 rsp_valid", int'(rsp_valid), 0);
        chk(req_ready === 1'b1, "R10 req_ready", int'(req_ready), 1);
        @(negedge clk);

        // R2: first read goes off-chip, requester is singlet owner.
        cyc(1, 0, 1, 0, 'h10, 1);
        // R1: further readers forward to the lowest holder (cache 1).
        cyc(1, 0, 3, 0, 'h10, 1);
        cyc(1, 0, 2, 0, 'h10, 1);
        cyc(1, 0, 0, 0, 'h10, 1);
        // R4: owner 1 drops, owner moves to 0; seen in next forward beat.
        cyc(1, 1, 1, 0, 'h10, 1);
        cyc(1, 0, 0, 0, 'h10, 1);   // R1: requester lowest, forward to 2
        cyc(1, 1, 0, 0, 'h10, 1);   // owner moves to 2
        cyc(1, 1, 3, 0, 'h10, 1);   // R3: singlet to 2
        // R5: last holder drops, entry gone, read fetches again.
        cyc(1, 1, 2, 0, 'h10, 1);
        cyc(1, 0, 3, 0, 'h10, 1);
        // R8: drops that change nothing, and op 3.
        cyc(1, 1, 1, 0, 'h99, 1);
        cyc(1, 1, 0, 0, 'h10, 1);
        cyc(1, 3, 0, 0, 'h10, 1);
        cyc(1, 0, 1, 0, 'h10, 1);   // forward to 3 shows state unchanged
        // R6: spill 3 -> 0, then a spill that leaves a singlet.
        cyc(1, 2, 3, 0, 'h10, 1);
        cyc(1, 0, 2, 0, 'h30, 1);
        cyc(1, 2, 2, 1, 'h30, 1);
        // R9: backpressure holds the beat and blocks requests.
        cyc(1, 0, 3, 0, 'h30, 0);
        cyc(1, 0, 2, 0, 'h30, 0);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(1, 0, 2, 0, 'h30, 1);
        cyc(0, 0, 0, 0, 0, 1);
        // R7: fill the table, stall an untracked read, free a slot.
        for (int i = 0; i < 6; i++) cyc(1, 0, i % 4, 0, 'h100 + i, 1);
        for (int i = 0; i < 3; i++) cyc(1, 0, 1, 0, 'h200, 1);
        cyc(1, 2, 0, 3, 'h201, 1);
        cyc(1, 0, 2, 0, 'h101, 1);  // tracked block still served
        cyc(1, 1, 0, 0, 'h100, 1);  // R5: frees a slot
        cyc(1, 0, 1, 0, 'h200, 1);

        // Mixed traffic against the reference model.
        for (int i = 0; i < 600; i++) begin
            int ra;
            ra = 'h400 + int'($urandom_range(0, 11));
            cyc(bit'($urandom_range(0, 4) != 0), int'($urandom_range(0, 3)),
                int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), ra,
                bit'($urandom_range(0, 3) != 0));
        end
        cyc(0, 0, 0, 0, 0, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule